// File: doc/BRIEF.md
# Message-Signalled Interrupt Pending/Queued Gate

This block sits between the message-signalled interrupt receive path and an interrupt presenter. Each source has an entry in a small register array. The entry holds a valid flag, a stored server field, an 8-bit priority and a generation value, plus two state bits: pending (P) and queued (Q). When a trigger strobe arrives, the block reads the entry for the addressed source. It then does one of three things: it forwards a delivery request to the presenter, it marks the interrupt as queued, or it drops the trigger. The entry is updated in the same cycle.

If the presenter turns a delivered interrupt away, it raises a reject for that source. The reject clears P and marks the source in a resend bitmap, which also keeps one summary bit per group of sources. Upstream logic reads the bitmap and replays the marked sources as triggers with the resend flag set. A resend trigger does not look at either stored state bit, so a rejected interrupt cannot be held back by leftover P or Q state. An entry port loads the per-source configuration, and a lookup port shows any entry's state.

Top module: `msi_pq_gate`

## Requirements
- R1: After reset every entry is invalid with P=0 and Q=0, the resend bitmap and its summary bits are all zero, and no delivery is presented.
- R2: A normal trigger to a valid source whose state {P,Q} is 00 and whose priority is not all ones sets P and presents a delivery request in the next cycle. The request carries server = stored server field shifted right by two, interrupt number = source number + IRQ_BASE, and the stored priority.
- R3: A priority of all ones (0xFF) masks a source: a trigger that evaluates to state 00 sets Q and presents no delivery.
- R4: A normal trigger in state {P,Q}=10 sets Q and presents no delivery.
- R5: A normal trigger in state 01 or 11 is dropped, with no change to P or Q and no delivery.
- R6: A resend trigger evaluates the state as 00 whatever P and Q hold, and then follows R2 or R3. It also clears that source's bit in the resend bitmap.
- R7: A reject clears P of the named source and sets its resend bitmap bit. Each summary bit i equals the OR of bitmap bits [i*GRP_SIZE +: GRP_SIZE]. If a reject and a resend trigger name the same source in the same cycle, the bit ends up set.
- R8: A trigger to a source whose entry is invalid changes no state, does not clear the bitmap, and presents no delivery.
- R9: One trigger is taken per cycle, and the read-modify-write finishes in that cycle, so a trigger in the next cycle to the same source sees the updated bits.
- R10: An entry write loads valid, server, priority and generation, and clears P, Q and the recorded generation. If it names the source being triggered, it takes effect after the trigger.
- R11: A delivery carries the entry's generation, and the same value is recorded in the entry, where the lookup port shows it.
- R12: When a trigger and a reject name the same source in the same cycle, the trigger is evaluated on the old state, and the reject's clearing of P is applied afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | SRC_W | Entry being written |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_server | input | SRV_W | Server field to store (low two bits are a link pointer) |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks) |
| cfg_gen | input | GEN_W | Generation to store |
| trig_valid | input | 1 | Trigger strobe |
| trig_src | input | SRC_W | Triggering source number |
| trig_resend | input | 1 | Trigger is a resend; stored P and Q are not evaluated |
| rej_valid | input | 1 | Presenter reject strobe |
| rej_src | input | SRC_W | Rejected source number |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_server | output | SRV_W-2 | Destination server |
| dlv_irq | output | IRQ_W | Global interrupt number |
| dlv_prio | output | PRIO_W | Delivered priority |
| dlv_gen | output | GEN_W | Generation of the delivered entry |
| rd_idx | input | SRC_W | Entry to look up |
| rd_valid | output | 1 | Looked-up entry valid flag |
| rd_pend | output | 1 | Looked-up P bit |
| rd_queued | output | 1 | Looked-up Q bit |
| rd_lgen | output | GEN_W | Looked-up recorded generation |
| rsd_map | output | NUM_SRC | Resend bitmap |
| rsd_sum | output | NUM_SRC/GRP_SIZE | Resend summary bits |

## Verification
Some properties are checked on every cycle. A delivery never carries the masking priority. Every delivery follows a trigger from one cycle earlier and carries that trigger's number plus the base. A trigger to an invalid source produces nothing. A reject always leaves its bitmap bit set. Each summary bit always matches its group. The full state machine can only be shown by the bench's scenarios, because a property would need the stored entry: the move from 00 to P, from 10 to Q, the drops in 01 and 11, resend overriding a stale P/Q, and the ordering of same-cycle trigger, reject and entry write.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

    // Outcome of evaluating one trigger against a source entry
    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_SEND  = 2'd1,
        ACT_QUEUE = 2'd2
    } pq_act_e;

endpackage

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
    import msi_pq_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              p_in,
    input  logic              q_in,
    input  logic              resend,
    input  logic [PRIO_W-1:0] prio,
    output pq_act_e           act,
    output logic              p_out,
    output logic              q_out
);

    logic [1:0] eff_st;

    always_comb begin
        // A resend looks at neither stored bit
        eff_st = resend ? 2'b00 : {p_in, q_in};
        p_out  = p_in;
        q_out  = q_in;
        act    = ACT_DROP;
        unique case (eff_st)
            2'b00: begin
                if (prio == {PRIO_W{1'b1}}) begin
                    act   = ACT_QUEUE;
                    q_out = 1'b1;
                end else begin
                    act   = ACT_SEND;
                    p_out = 1'b1;
                end
            end
            2'b10: begin
                act   = ACT_QUEUE;
                q_out = 1'b1;
            end
            default: begin
                act = ACT_DROP;
            end
        endcase
    end

endmodule

// File: rtl/msi_rsd_map.sv
module msi_rsd_map #(
    parameter int NUM_SRC  = 16,
    parameter int GRP_SIZE = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int NUM_GRP = NUM_SRC / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [SRC_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [SRC_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] map_q,
    output logic [NUM_GRP-1:0] sum_q
);

    logic [NUM_SRC-1:0] map_d;
    logic [NUM_GRP-1:0] sum_d;

    always_comb begin
        map_d = map_q;
        if (clr_en) map_d[clr_idx] = 1'b0;
        if (set_en) map_d[set_idx] = 1'b1;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum
        assign sum_d[g] = |map_d[g*GRP_SIZE +: GRP_SIZE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
            sum_q <= '0;
        end else begin
            map_q <= map_d;
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
    import msi_pq_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int SRV_W    = 8,
    parameter int PRIO_W   = 8,
    parameter int GEN_W    = 2,
    parameter int IRQ_W    = 12,
    parameter int IRQ_BASE = 256,
    parameter int GRP_SIZE = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int DST_W   = SRV_W - 2,
    localparam int NUM_GRP = NUM_SRC / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [GEN_W-1:0]   cfg_gen,
    input  logic               trig_valid,
    input  logic [SRC_W-1:0]   trig_src,
    input  logic               trig_resend,
    input  logic               rej_valid,
    input  logic [SRC_W-1:0]   rej_src,
    output logic               dlv_valid,
    output logic [DST_W-1:0]   dlv_server,
    output logic [IRQ_W-1:0]   dlv_irq,
    output logic [PRIO_W-1:0]  dlv_prio,
    output logic [GEN_W-1:0]   dlv_gen,
    input  logic [SRC_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic               rd_pend,
    output logic               rd_queued,
    output logic [GEN_W-1:0]   rd_lgen,
    output logic [NUM_SRC-1:0] rsd_map,
    output logic [NUM_GRP-1:0] rsd_sum
);

    localparam logic [IRQ_W-1:0] BASE_L = IRQ_W'(IRQ_BASE);

    typedef struct packed {
        logic              vld;
        logic [SRV_W-1:0]  srv;
        logic [PRIO_W-1:0] prio;
        logic [GEN_W-1:0]  gen;
        logic [GEN_W-1:0]  lgen;
        logic              p;
        logic              q;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_SRC-1:0] ent;
        logic               dv;
        logic [DST_W-1:0]   dsrv;
        logic [IRQ_W-1:0]   dirq;
        logic [PRIO_W-1:0]  dprio;
        logic [GEN_W-1:0]   dgen;
    } state_t;

    state_t st_d, st_q;

    ent_t    cur_ent;
    logic    accept;
    pq_act_e act;
    logic    nxt_p, nxt_q;
    logic [NUM_SRC-1:0] vld_vec;

    assign cur_ent = st_q.ent[trig_src];
    assign accept  = trig_valid && cur_ent.vld;

    msi_pq_decide #(.PRIO_W(PRIO_W)) u_decide (
        .p_in   (cur_ent.p),
        .q_in   (cur_ent.q),
        .resend (trig_resend),
        .prio   (cur_ent.prio),
        .act    (act),
        .p_out  (nxt_p),
        .q_out  (nxt_q)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        // 1. trigger evaluated on the registered entry
        if (accept) begin
            st_d.ent[trig_src].p = nxt_p;
            st_d.ent[trig_src].q = nxt_q;
            if (act == ACT_SEND) begin
                st_d.dv                 = 1'b1;
                st_d.dsrv               = cur_ent.srv[SRV_W-1:2];
                st_d.dirq               = IRQ_W'(trig_src) + BASE_L;
                st_d.dprio              = cur_ent.prio;
                st_d.dgen               = cur_ent.gen;
                st_d.ent[trig_src].lgen = cur_ent.gen;
            end
        end
        // 2. reject drops pending after the trigger
        if (rej_valid) begin
            st_d.ent[rej_src].p = 1'b0;
        end
        // 3. entry write overrides the addressed entry
        if (cfg_we) begin
            st_d.ent[cfg_idx].vld  = cfg_valid;
            st_d.ent[cfg_idx].srv  = cfg_server;
            st_d.ent[cfg_idx].prio = cfg_prio;
            st_d.ent[cfg_idx].gen  = cfg_gen;
            st_d.ent[cfg_idx].lgen = '0;
            st_d.ent[cfg_idx].p    = 1'b0;
            st_d.ent[cfg_idx].q    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    msi_rsd_map #(.NUM_SRC(NUM_SRC), .GRP_SIZE(GRP_SIZE)) u_rsd (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (rej_valid),
        .set_idx (rej_src),
        .clr_en  (accept && trig_resend),
        .clr_idx (trig_src),
        .map_q   (rsd_map),
        .sum_q   (rsd_sum)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_vld
        assign vld_vec[s] = st_q.ent[s].vld;
    end

    assign dlv_valid  = st_q.dv;
    assign dlv_server = st_q.dsrv;
    assign dlv_irq    = st_q.dirq;
    assign dlv_prio   = st_q.dprio;
    assign dlv_gen    = st_q.dgen;

    assign rd_valid  = st_q.ent[rd_idx].vld;
    assign rd_pend   = st_q.ent[rd_idx].p;
    assign rd_queued = st_q.ent[rd_idx].q;
    assign rd_lgen   = st_q.ent[rd_idx].lgen;

endmodule

// File: rtl/msi_pq_gate_chk.sv
module msi_pq_gate_chk #(
    parameter int NUM_SRC  = 16,
    parameter int PRIO_W   = 8,
    parameter int IRQ_W    = 12,
    parameter int IRQ_BASE = 256,
    parameter int GRP_SIZE = 4,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int NUM_GRP = NUM_SRC / GRP_SIZE
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_valid,
    input logic [SRC_W-1:0]   trig_src,
    input logic               rej_valid,
    input logic [SRC_W-1:0]   rej_src,
    input logic               dlv_valid,
    input logic [IRQ_W-1:0]   dlv_irq,
    input logic [PRIO_W-1:0]  dlv_prio,
    input logic [NUM_SRC-1:0] rsd_map,
    input logic [NUM_GRP-1:0] rsd_sum,
    input logic [NUM_SRC-1:0] src_vld
);

    p_dlv_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != {PRIO_W{1'b1}});

    p_dlv_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ($past(trig_valid) &&
                       dlv_irq == IRQ_W'($past(trig_src)) + IRQ_W'(IRQ_BASE)));

    p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !src_vld[trig_src]) |=> !dlv_valid);

    p_reject_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |=> rsd_map[$past(rej_src)]);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum_chk
        p_sum_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rsd_sum[g] == (|rsd_map[g*GRP_SIZE +: GRP_SIZE]));
    end

endmodule

bind msi_pq_gate msi_pq_gate_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IRQ_W(IRQ_W),
    .IRQ_BASE(IRQ_BASE), .GRP_SIZE(GRP_SIZE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_src   (trig_src),
    .rej_valid  (rej_valid),
    .rej_src    (rej_src),
    .dlv_valid  (dlv_valid),
    .dlv_irq    (dlv_irq),
    .dlv_prio   (dlv_prio),
    .rsd_map    (rsd_map),
    .rsd_sum    (rsd_sum),
    .src_vld    (vld_vec)
);

// File: tb/tb_msi_pq_gate.sv
module tb_msi_pq_gate;

    localparam int CLK_P = 10;
    localparam int NS    = 16;
    localparam int GS    = 4;
    localparam int BASE  = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_valid, trig_valid, trig_resend, rej_valid;
    logic [3:0]  cfg_idx, trig_src, rej_src, rd_idx;
    logic [7:0]  cfg_server, cfg_prio;
    logic [1:0]  cfg_gen;
    logic        dlv_valid, rd_valid, rd_pend, rd_queued;
    logic [5:0]  dlv_server;
    logic [11:0] dlv_irq;
    logic [7:0]  dlv_prio;
    logic [1:0]  dlv_gen, rd_lgen;
    logic [15:0] rsd_map;
    logic [3:0]  rsd_sum;

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic       mv [NS];
    logic [7:0] msrv [NS];
    logic [7:0] mpr [NS];
    logic [1:0] mgen [NS];
    logic [1:0] mlg [NS];
    logic       mp [NS];
    logic       mq [NS];
    logic [15:0] mmap;

    always #(CLK_P/2) clk = ~clk;

    msi_pq_gate dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_gen(cfg_gen),
        .trig_valid(trig_valid), .trig_src(trig_src), .trig_resend(trig_resend),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .dlv_valid(dlv_valid), .dlv_server(dlv_server), .dlv_irq(dlv_irq),
        .dlv_prio(dlv_prio), .dlv_gen(dlv_gen),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_pend(rd_pend),
        .rd_queued(rd_queued), .rd_lgen(rd_lgen),
        .rsd_map(rsd_map), .rsd_sum(rsd_sum)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sum(input logic [15:0] m);
        logic [3:0] s;
        for (int g = 0; g < NS/GS; g++) s[g] = |m[g*GS +: GS];
        return s;
    endfunction

    // look at one entry through the lookup port
    task automatic peek(input logic [3:0] idx, input string req);
        rd_idx = idx;
        #1;
        chk(rd_valid == mv[idx], req, "valid", rd_valid, mv[idx]);
        chk({rd_pend, rd_queued} == {mp[idx], mq[idx]}, req, "pq",
            {rd_pend, rd_queued}, {mp[idx], mq[idx]});
        chk(rd_lgen == mlg[idx], req, "lgen", rd_lgen, mlg[idx]);
        chk(rsd_map == mmap, req, "map", rsd_map, mmap);
        chk(rsd_sum == exp_sum(mmap), req, "sum", rsd_sum, exp_sum(mmap));
    endtask

    // one clock: drive at negedge, model, check registered outputs after edge
    task automatic step(input logic tv, input logic [3:0] ts, input logic tr,
                        input logic rv, input logic [3:0] rs,
                        input logic cw, input logic [3:0] ci, input logic cv,
                        input logic [7:0] csrv, input logic [7:0] cpr,
                        input logic [1:0] cg, input string req);
        logic       e_dv, acc;
        logic [5:0] e_srv;
        logic [11:0] e_irq;
        logic [7:0] e_pr;
        logic [1:0] e_gen, st;
        trig_valid = tv; trig_src = ts; trig_resend = tr;
        rej_valid = rv; rej_src = rs;
        cfg_we = cw; cfg_idx = ci; cfg_valid = cv;
        cfg_server = csrv; cfg_prio = cpr; cfg_gen = cg;
        e_dv = 1'b0; e_srv = '0; e_irq = '0; e_pr = '0; e_gen = '0;
        acc = tv && mv[ts];
        if (acc) begin
            st = tr ? 2'b00 : {mp[ts], mq[ts]};
            if (st == 2'b00) begin
                if (mpr[ts] == 8'hFF) mq[ts] = 1'b1;
                else begin
                    mp[ts] = 1'b1; e_dv = 1'b1;
                    e_srv = msrv[ts][7:2];
                    e_irq = 12'(ts) + 12'(BASE);
                    e_pr = mpr[ts]; e_gen = mgen[ts]; mlg[ts] = mgen[ts];
                end
            end else if (st == 2'b10) mq[ts] = 1'b1;
            if (tr) mmap[ts] = 1'b0;
        end
        if (rv) begin mp[rs] = 1'b0; mmap[rs] = 1'b1; end
        if (cw) begin
            mv[ci] = cv; msrv[ci] = csrv; mpr[ci] = cpr; mgen[ci] = cg;
            mlg[ci] = '0; mp[ci] = 1'b0; mq[ci] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        trig_valid = 0; rej_valid = 0; cfg_we = 0;
        chk(dlv_valid == e_dv, req, "dlv_valid", dlv_valid, e_dv);
        if (e_dv && dlv_valid) begin
            chk(dlv_server == e_srv, req, "server", dlv_server, e_srv);
            chk(dlv_irq == e_irq, req, "irq", dlv_irq, e_irq);
            chk(dlv_prio == e_pr, req, "prio", dlv_prio, e_pr);
            chk(dlv_gen == e_gen, req, "gen", dlv_gen, e_gen);
        end
    endtask

    task automatic trig(input logic [3:0] s, input logic r, input string req);
        step(1, s, r, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic load(input logic [3:0] s, input logic [7:0] sv,
                        input logic [7:0] pr, input logic [1:0] g);
        step(0, 0, 0, 0, 0, 1, s, 1, sv, pr, g, "R10");
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        for (int i = 0; i < NS; i++) begin
            mv[i] = 0; msrv[i] = 0; mpr[i] = 0; mgen[i] = 0;
            mlg[i] = 0; mp[i] = 0; mq[i] = 0;
        end
        mmap = '0;
        rst_n = 0; trig_valid = 0; rej_valid = 0; cfg_we = 0;
        trig_src = 0; trig_resend = 0; rej_src = 0; cfg_idx = 0; cfg_valid = 0;
        cfg_server = 0; cfg_prio = 0; cfg_gen = 0; rd_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(dlv_valid == 1'b0, "R1", "dlv_valid", dlv_valid, 0);
        for (int i = 0; i < NS; i += 5) peek(4'(i), "R1");

        // R2 delivery from state 00; R11 generation
        load(3, 8'h25, 8'h05, 2'd2);
        peek(3, "R10");
        trig(3, 0, "R2");
        peek(3, "R11");
        // R4 / R9 back-to-back sees P
        trig(3, 0, "R4");
        peek(3, "R9");
        // R5 drop in 11
        trig(3, 0, "R5");
        peek(3, "R5");
        // R6 resend ignores P and Q
        trig(3, 1, "R6");
        peek(3, "R6");
        // R7 reject marks bitmap and summary
        step(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, "R7");
        peek(3, "R7");
        step(0, 0, 0, 1, 14, 0, 0, 0, 0, 0, 0, "R7");
        peek(14, "R7");
        // R5 drop in 01 (P cleared, Q still set)
        trig(3, 0, "R5");
        peek(3, "R5");
        // R6 resend clears bitmap bit and delivers despite Q
        trig(3, 1, "R6");
        peek(3, "R6");
        // R7 reject and resend same source same cycle: bit stays set
        step(1, 3, 1, 1, 3, 0, 0, 0, 0, 0, 0, "R7");
        peek(3, "R7");
        // R3 masked source
        load(7, 8'hF0, 8'hFF, 2'd1);
        trig(7, 0, "R3");
        peek(7, "R3");
        trig(7, 1, "R3");
        peek(7, "R3");
        // R8 invalid source, also resend with bitmap bit set
        step(0, 0, 0, 1, 9, 0, 0, 0, 0, 0, 0, "R7");
        trig(9, 1, "R8");
        peek(9, "R8");
        trig(9, 0, "R8");
        peek(9, "R8");
        // R12 trigger and reject same source same cycle
        load(5, 8'h0B, 8'h40, 2'd3);
        step(1, 5, 0, 1, 5, 0, 0, 0, 0, 0, 0, "R12");
        peek(5, "R12");
        // R10 write during a trigger to the same source
        trig(5, 0, "R10");
        step(1, 5, 0, 0, 0, 1, 5, 1, 8'h80, 8'h01, 2'd0, "R10");
        peek(5, "R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic       tv, tr, rv, cw, cv;
            logic [3:0] ts, rs, ci;
            logic [7:0] cs, cp;
            tv = ($urandom % 4) != 0;
            tr = ($urandom % 4) == 0;
            rv = ($urandom % 6) == 0;
            cw = ($urandom % 8) == 0;
            cv = ($urandom % 8) != 0;
            ts = 4'($urandom); rs = 4'($urandom); ci = 4'($urandom);
            cs = 8'($urandom);
            cp = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom % 255);
            step(tv, ts, tr, rv, rs, cw, ci, cv, cs, cp, 2'($urandom), "R9");
            peek(4'($urandom), "R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule